// File: doc/BRIEF.md
# Four-Lane Active-Window Timing Generator

This block produces the data-enable timing for a 1920x1080 panel whose pixels arrive four per clock over four parallel ports. A column counter steps through each line in clock units (480 active clocks plus horizontal blanking), and a line counter steps through the frame (1080 active lines plus vertical blanking). The enable output is high only inside the active window. The sink ignores sync pulses, so the enable is the only thing that marks line and frame edges. A one-clock frame-start pulse, the two counters and the pixel index carried on each port are also provided. The pixel index is meaningful while the enable is high.

Two frame-rate profiles are supported. They differ only in the allowed vertical blanking range. The blanking lengths are runtime inputs. They are sampled once per frame, on its last clock, and clamped to the limits of the selected profile. A sticky flag records any clamped request. There is no data stream through this block, so every pin is a plain level or pulse with no handshake. The geometry and all limits are parameters. The defaults match the panel.

Top module: `quad_de_timing_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next outputs are `de_o`=0, `frame_start_o`=0, `col_o`=0, `line_o`=0, `cfg_err_o`=0. The frame after reset uses the default blanking values of profile 0: 70 clocks and 45 lines.
- R2: `col_o` counts 0, 1, ... up to H_ACT+hblank-1, then returns to 0. H_ACT defaults to 480.
- R3: `line_o` increments each time `col_o` wraps, and returns to 0 after line V_ACT+vblank-1. V_ACT defaults to 1080.
- R4: `de_o` is 1 exactly when `col_o` < H_ACT and `line_o` < V_ACT.
- R5: `frame_start_o` is a one-clock pulse. It is high exactly when `de_o`=1, `col_o`=0 and `line_o`=0.
- R6: Port p (p = 0..3) carries pixel `col_o`*4+p on field `pix_idx_o[p*PIX_W +: PIX_W]`. Port 0 takes the lowest bits.
- R7: `mode_sel`=0 selects the 120 Hz profile, which allows vertical blanking of 16 to 86 lines. `mode_sel`=1 selects the 100 Hz profile, which allows 228 to 300 lines. Horizontal blanking is 40 to 200 clocks in both profiles.
- R8: A blanking request below or above its limits is replaced by the nearest limit.
- R9: `cfg_err_o` rises when an out-of-range request is sampled, and stays high until reset.
- R10: `mode_sel`, `hblank_req` and `vblank_req` are sampled only on the last clock of a frame. Changes at other times have no effect on the current frame.
- R11: The outputs are registered. The clock edge that first samples `rst` low shows column 0, line 0, with `de_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Profile select: 0 = 120 Hz limits, 1 = 100 Hz limits |
| hblank_req | input | HB_W | Requested horizontal blanking, in clocks |
| vblank_req | input | VB_W | Requested vertical blanking, in lines |
| de_o | output | 1 | Active-window enable |
| frame_start_o | output | 1 | Pulse on the first active clock of a frame |
| col_o | output | COL_W | Clock position within the line |
| line_o | output | LINE_W | Line position within the frame |
| pix_idx_o | output | LANES*PIX_W | Pixel index on each port, port 0 in the lowest field |
| cfg_err_o | output | 1 | Sticky flag for a clamped blanking request |

## Verification
The assertions check on every cycle:
- the enable stays inside the active window;
- the frame-start pulse matches position zero;
- the column steps by one across the active region;
- the error flag is sticky;
- the latched blanking values stay within their limits and change only at a frame end.

Only the bench's scenarios can show:
- the exact line and frame lengths under each profile;
- the clamped values that result from out-of-range requests;
- that changes made mid-frame are ignored until the frame boundary;
- the per-port pixel order.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  typedef enum logic {
    PROF_FAST = 1'b0,
    PROF_SLOW = 1'b1
  } profile_e;
endpackage

// File: rtl/qdt_cfg.sv
// Clamps blanking requests to the selected profile's limits and holds them
// for a whole frame; loads only on the frame's last clock.
module qdt_cfg #(
  parameter int HB_W = 8,
  parameter int VB_W = 9,
  parameter int HB_MIN = 40,
  parameter int HB_MAX = 200,
  parameter int HB_DEF = 70,
  parameter int VBA_MIN = 16,
  parameter int VBA_MAX = 86,
  parameter int VBA_DEF = 45,
  parameter int VBB_MIN = 228,
  parameter int VBB_MAX = 300
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            mode_sel,
  input  logic [HB_W-1:0] hb_raw,
  input  logic [VB_W-1:0] vb_raw,
  output logic [HB_W-1:0] hb_q,
  output logic [VB_W-1:0] vb_q,
  output logic            err_q
);
  import qdt_pkg::*;

  profile_e        prof;
  logic [VB_W-1:0] vb_lo, vb_hi;
  logic [HB_W-1:0] hb_c;
  logic [VB_W-1:0] vb_c;
  logic            hb_low, hb_high, vb_low, vb_high;

  always_comb begin
    prof    = profile_e'(mode_sel);
    vb_lo   = (prof == PROF_SLOW) ? VB_W'(VBB_MIN) : VB_W'(VBA_MIN);
    vb_hi   = (prof == PROF_SLOW) ? VB_W'(VBB_MAX) : VB_W'(VBA_MAX);
    hb_low  = hb_raw < HB_W'(HB_MIN);
    hb_high = hb_raw > HB_W'(HB_MAX);
    vb_low  = vb_raw < vb_lo;
    vb_high = vb_raw > vb_hi;
    hb_c    = hb_low ? HB_W'(HB_MIN) : (hb_high ? HB_W'(HB_MAX) : hb_raw);
    vb_c    = vb_low ? vb_lo : (vb_high ? vb_hi : vb_raw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_q  <= HB_W'(HB_DEF);
      vb_q  <= VB_W'(VBA_DEF);
      err_q <= 1'b0;
    end else if (load) begin
      hb_q  <= hb_c;
      vb_q  <= vb_c;
      err_q <= err_q | hb_low | hb_high | vb_low | vb_high;
    end
  end
endmodule

// File: rtl/qdt_counter.sv
// Column and line counters; column wraps at h_last, line wraps at v_last.
module qdt_counter #(
  parameter int COL_W = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COL_W-1:0]  h_last,
  input  logic [LINE_W-1:0] v_last,
  output logic [COL_W-1:0]  col,
  output logic [LINE_W-1:0] line,
  output logic              frame_end
);
  logic col_wrap, line_wrap;

  always_comb begin
    col_wrap  = (col == h_last);
    line_wrap = (line == v_last);
    frame_end = col_wrap & line_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col  <= '0;
      line <= '0;
    end else if (col_wrap) begin
      col  <= '0;
      line <= line_wrap ? '0 : line + LINE_W'(1);
    end else begin
      col <= col + COL_W'(1);
    end
  end
endmodule

// File: rtl/qdt_lane_map.sv
// Pixel index per port: port p carries column*LANES + p.
module qdt_lane_map #(
  parameter int COL_W = 10,
  parameter int PIX_W = 11,
  parameter int LANES = 4
) (
  input  logic [COL_W-1:0]       col,
  output logic [LANES*PIX_W-1:0] pix
);
  for (genvar p = 0; p < LANES; p++) begin : g_lane
    assign pix[p*PIX_W +: PIX_W] = PIX_W'(int'(col) * LANES + p);
  end
endmodule

// File: rtl/quad_de_timing_gen.sv
module quad_de_timing_gen #(
  parameter int H_ACT = 480,
  parameter int V_ACT = 1080,
  parameter int LANES = 4,
  parameter int HB_W = 8,
  parameter int VB_W = 9,
  parameter int HB_MIN = 40,
  parameter int HB_MAX = 200,
  parameter int HB_DEF = 70,
  parameter int VBA_MIN = 16,
  parameter int VBA_MAX = 86,
  parameter int VBA_DEF = 45,
  parameter int VBB_MIN = 228,
  parameter int VBB_MAX = 300,
  localparam int VB_TOP = (VBA_MAX > VBB_MAX) ? VBA_MAX : VBB_MAX,
  localparam int COL_W = $clog2(H_ACT + HB_MAX),
  localparam int LINE_W = $clog2(V_ACT + VB_TOP),
  localparam int PIX_W = $clog2(H_ACT * LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_sel,
  input  logic [HB_W-1:0]        hblank_req,
  input  logic [VB_W-1:0]        vblank_req,
  output logic                   de_o,
  output logic                   frame_start_o,
  output logic [COL_W-1:0]       col_o,
  output logic [LINE_W-1:0]      line_o,
  output logic [LANES*PIX_W-1:0] pix_idx_o,
  output logic                   cfg_err_o
);
  logic [HB_W-1:0]   hb_q;
  logic [VB_W-1:0]   vb_q;
  logic [COL_W-1:0]  h_last, col;
  logic [LINE_W-1:0] v_last, line;
  logic              frame_end, active;

  qdt_cfg #(
    .HB_W(HB_W), .VB_W(VB_W), .HB_MIN(HB_MIN), .HB_MAX(HB_MAX), .HB_DEF(HB_DEF),
    .VBA_MIN(VBA_MIN), .VBA_MAX(VBA_MAX), .VBA_DEF(VBA_DEF),
    .VBB_MIN(VBB_MIN), .VBB_MAX(VBB_MAX)
  ) cfg_i (
    .clk(clk), .rst(rst), .load(frame_end), .mode_sel(mode_sel),
    .hb_raw(hblank_req), .vb_raw(vblank_req),
    .hb_q(hb_q), .vb_q(vb_q), .err_q(cfg_err_o)
  );

  always_comb begin
    h_last = COL_W'(H_ACT) + COL_W'(hb_q) - COL_W'(1);
    v_last = LINE_W'(V_ACT) + LINE_W'(vb_q) - LINE_W'(1);
    active = (col < COL_W'(H_ACT)) && (line < LINE_W'(V_ACT));
  end

  qdt_counter #(.COL_W(COL_W), .LINE_W(LINE_W)) cnt_i (
    .clk(clk), .rst(rst), .h_last(h_last), .v_last(v_last),
    .col(col), .line(line), .frame_end(frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o          <= 1'b0;
      frame_start_o <= 1'b0;
      col_o         <= '0;
      line_o        <= '0;
    end else begin
      de_o          <= active;
      frame_start_o <= active && (col == '0) && (line == '0);
      col_o         <= col;
      line_o        <= line;
    end
  end

  qdt_lane_map #(.COL_W(COL_W), .PIX_W(PIX_W), .LANES(LANES)) map_i (
    .col(col_o), .pix(pix_idx_o)
  );
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
  parameter int H_ACT = 480,
  parameter int V_ACT = 1080,
  parameter int HB_W = 8,
  parameter int VB_W = 9,
  parameter int HB_MIN = 40,
  parameter int HB_MAX = 200,
  parameter int VB_LOW = 16,
  parameter int VB_HIGH = 300,
  parameter int COL_W = 10,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              de,
  input logic              frame_start,
  input logic [COL_W-1:0]  col,
  input logic [LINE_W-1:0] line,
  input logic              err,
  input logic              frame_end,
  input logic [HB_W-1:0]   hb_q,
  input logic [VB_W-1:0]   vb_q
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!de && !frame_start && col == '0 && line == '0 && !err));

  assert_col_step_R2: assert property (@(posedge clk) disable iff (rst)
    (de && col != COL_W'(H_ACT - 1)) |=> (col == $past(col) + COL_W'(1)));

  assert_de_window_R4: assert property (@(posedge clk) disable iff (rst)
    de |-> (col < COL_W'(H_ACT) && line < LINE_W'(V_ACT)));

  assert_frame_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (de && col == '0 && line == '0));

  assert_vb_limits_R7: assert property (@(posedge clk) disable iff (rst)
    (vb_q >= VB_W'(VB_LOW) && vb_q <= VB_W'(VB_HIGH)));

  assert_hb_limits_R8: assert property (@(posedge clk) disable iff (rst)
    (hb_q >= HB_W'(HB_MIN) && hb_q <= HB_W'(HB_MAX)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(hb_q) && $stable(vb_q)));
endmodule

bind quad_de_timing_gen qdt_checker #(
  .H_ACT(H_ACT), .V_ACT(V_ACT), .HB_W(HB_W), .VB_W(VB_W),
  .HB_MIN(HB_MIN), .HB_MAX(HB_MAX),
  .VB_LOW((VBA_MIN < VBB_MIN) ? VBA_MIN : VBB_MIN), .VB_HIGH(VB_TOP),
  .COL_W(COL_W), .LINE_W(LINE_W)
) chk_i (
  .clk(clk), .rst(rst), .de(de_o), .frame_start(frame_start_o),
  .col(col_o), .line(line_o), .err(cfg_err_o), .frame_end(frame_end),
  .hb_q(hb_q), .vb_q(vb_q)
);

// File: tb/quad_de_timing_gen_tb_top.sv
`timescale 1ns/1ps
module quad_de_timing_gen_tb_top;
  localparam int H = 4, V = 3, LN = 4;
  localparam int HBW = 3, VBW = 3;
  localparam int HBMIN = 2, HBMAX = 5, HBDEF = 3;
  localparam int VAMIN = 1, VAMAX = 3, VADEF = 2;
  localparam int VBMIN = 4, VBMAX = 6;
  localparam int CW = $clog2(H + HBMAX);
  localparam int LW = $clog2(V + VBMAX);
  localparam int PW = $clog2(H * LN);

  logic clk = 1'b0, rst = 1'b1, mode = 1'b0;
  logic [HBW-1:0] hreq = HBW'(HBDEF);
  logic [VBW-1:0] vreq = VBW'(VADEF);
  logic de, fs, err;
  logic [CW-1:0] col;
  logic [LW-1:0] line;
  logic [LN*PW-1:0] pix;

  int nchk = 0, nerr = 0;
  int e_col, e_line, e_hb, e_vb;
  bit e_err, live, first, clamp_frame, finished;
  string ctx = "";

  always #2.5 clk = ~clk;

  quad_de_timing_gen #(
    .H_ACT(H), .V_ACT(V), .LANES(LN), .HB_W(HBW), .VB_W(VBW),
    .HB_MIN(HBMIN), .HB_MAX(HBMAX), .HB_DEF(HBDEF),
    .VBA_MIN(VAMIN), .VBA_MAX(VAMAX), .VBA_DEF(VADEF),
    .VBB_MIN(VBMIN), .VBB_MAX(VBMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode), .hblank_req(hreq), .vblank_req(vreq),
    .de_o(de), .frame_start_o(fs), .col_o(col), .line_o(line),
    .pix_idx_o(pix), .cfg_err_o(err)
  );

  function automatic int lo_v(bit m); return m ? VBMIN : VAMIN; endfunction
  function automatic int hi_v(bit m); return m ? VBMAX : VAMAX; endfunction
  function automatic int clampi(int x, int lo, int hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (live) begin
      int  act, nhb, nvb;
      bit  lc, ll, oor;
      act = (e_col < H && e_line < V);
      lc  = (e_col == H + e_hb - 1);
      ll  = (e_line == V + e_vb - 1);
      nhb = e_hb; nvb = e_vb;
      oor = 0;
      if (lc && ll) begin
        oor = (hreq < HBMIN || hreq > HBMAX || vreq < lo_v(mode) || vreq > hi_v(mode));
        if (oor) e_err = 1;
        nhb = clampi(hreq, HBMIN, HBMAX);
        nvb = clampi(vreq, lo_v(mode), hi_v(mode));
      end
      if (first) begin
        chk("R11 first col", col, 0);
        chk("R11 first de", de, 1);
        first = 0;
      end
      chk({"R4 de", ctx}, de, act);
      chk({"R5 frame_start", ctx}, fs, (act && e_col == 0 && e_line == 0));
      chk({clamp_frame ? "R8 col" : "R2 col", ctx}, col, e_col);
      chk({ll ? "R7 last line" : "R3 line", ctx}, line, e_line);
      chk({"R9 err", ctx}, err, e_err);
      if (act)
        for (int p = 0; p < LN; p++)
          chk("R6 lane pixel", pix[p*PW +: PW], e_col * LN + p);
      if (lc) begin
        e_col = 0;
        if (ll) begin
          e_line = 0; e_hb = nhb; e_vb = nvb; clamp_frame = oor;
        end else e_line++;
      end else e_col++;
    end
  endtask

  task automatic do_reset();
    rst  = 1'b1;
    live = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset de", de, 0);
    chk("R1 reset frame_start", fs, 0);
    chk("R1 reset col", col, 0);
    chk("R1 reset line", line, 0);
    chk("R1 reset err", err, 0);
    rst = 1'b0;
    e_col = 0; e_line = 0; e_hb = HBDEF; e_vb = VADEF; e_err = 0;
    clamp_frame = 0; first = 1; live = 1;
  endtask

  // pol 0: hold; 1: in-range changes at random times; 2: any value
  task automatic run(int n, int pol);
    for (int i = 0; i < n; i++) begin
      step();
      if (pol != 0 && ($urandom % 6) == 0) begin
        if (pol == 1) begin
          hreq = HBW'(HBMIN + $urandom % (HBMAX - HBMIN + 1));
          vreq = VBW'(lo_v(mode) + $urandom % (hi_v(mode) - lo_v(mode) + 1));
        end else begin
          hreq = HBW'($urandom);
          vreq = VBW'($urandom);
          mode = 1'($urandom);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // default profile, inputs steady
    ctx = " R7"; run(200, 0);
    // mid-frame changes only matter at the frame end
    ctx = " R10"; run(600, 1);
    // slow profile
    mode = 1'b1; vreq = VBW'(VBMIN); ctx = " R7"; run(300, 0);
    vreq = VBW'(VBMAX); run(200, 0);
    // clamping corners
    ctx = " R8"; hreq = HBW'(7); vreq = VBW'(7); run(200, 0);
    hreq = HBW'(0); vreq = VBW'(0); run(200, 0);
    mode = 1'b0; hreq = HBW'(HBMAX); vreq = VBW'(5); run(200, 0);
    // random mix
    ctx = " R9"; run(3000, 2);
    // reset mid-frame clears the flag
    repeat (17) step();
    do_reset();
    ctx = " R1"; hreq = HBW'(HBMIN); vreq = VBW'(VAMAX); mode = 1'b0; run(300, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule